// File: doc/BRIEF.md
# USB Host Data-Buffer Error Responder

This block sits between the memory-side buffers of a USB host controller and its packet engine. It decides how a transaction ends on the bus when the buffer cannot keep up with the wire. On an OUT transaction it streams the payload from the transmit FIFO, one byte per cycle. If the FIFO runs dry before the declared length is reached, it keeps the byte timing regular by repeating the last byte it sent. It then ends the packet with a CRC that is deliberately wrong, so the device has to discard it. On an IN transaction it watches the receive FIFO. If a byte arrives while that FIFO is full, the block withholds the handshake, and the device resends the same data with the same toggle.

Either case raises a buffer-error flag in the completion status. A buffer error is not a transaction error, so the transaction-error indication that feeds the retry counter stays low. The data toggle is never allowed to advance on a transaction that hit a buffer error. Isochronous transactions never receive a handshake. They still report the buffer-error flag.

Top module: `usb_dbe_responder`

## Requirements
- R1: After reset, and until the first start, tx_valid, tx_last, tx_byte, tx_pop, rx_wr, done, buf_err, xact_err, hs_ack and toggle_adv are all 0.
- R2: start with dir_in=0 sampled at clock edge e0 produces exactly pkt_len payload bytes on tx_byte, with tx_valid high. The byte for slot k appears after edge e(k+1). tx_pop is high during slot k exactly when tx_empty is 0, and each popped tx_data byte is sent in FIFO order.
- R3: After the payload come two CRC bytes, low byte first, with tx_last high only on the second. Without an underrun the pair is the bitwise inverse of the CRC-16 remainder. That remainder uses polynomial x^16+x^15+x^2+1, seed 0xFFFF and LSB-first processing over the bytes as sent. For the bytes 0x31..0x39 the pair is 0xC8, 0xB4.
- R4: A payload slot with tx_empty=1 is an underrun. The block sends the previous byte of the same packet in that slot, or 0x00 if it is the first slot, and pops nothing.
- R5: If any payload slot underran, the two CRC bytes are the raw remainder, not its inverse.
- R6: During an IN, rx_wr equals rx_valid and not rx_full. A byte with rx_valid=1 and rx_full=1, including the last byte, is an overrun.
- R7: done is a one-cycle pulse that carries the status. For an OUT it comes one cycle after tx_last. For an IN it comes in the cycle after the edge that samples rx_eop. buf_err is 1 exactly when the transaction had an underrun or an overrun.
- R8: hs_ack is 1 only with done, and only for an IN that is not isochronous, had no overrun and had rx_bad=0 with rx_eop.
- R9: xact_err equals rx_bad as sampled with rx_eop. It is 0 for every OUT, so a buffer error alone never raises it.
- R10: toggle_adv at done is 1 exactly when there was no buffer error, xact_err is 0 and iso was 0 at start.
- R11: An OUT with pkt_len=0 sends only the CRC pair, 0x00 and 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (taken only when idle) |
| dir_in | input | 1 | 1 = IN, 0 = OUT |
| iso | input | 1 | Isochronous transaction |
| pkt_len | input | LEN_W | Declared OUT payload length in bytes |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 8 | Transmit FIFO head byte |
| tx_pop | output | 1 | Consume the transmit FIFO head |
| tx_valid | output | 1 | tx_byte valid this cycle |
| tx_byte | output | 8 | Byte to the packet engine |
| tx_last | output | 1 | Final byte of the packet |
| rx_valid | input | 1 | Received byte present |
| rx_full | input | 1 | Receive FIFO full |
| rx_eop | input | 1 | End of received packet |
| rx_bad | input | 1 | Packet-level error reported with rx_eop |
| rx_wr | output | 1 | Write received byte into the FIFO |
| done | output | 1 | Completion pulse |
| buf_err | output | 1 | Data-buffer error status |
| xact_err | output | 1 | Transaction error status |
| hs_ack | output | 1 | Issue ACK handshake |
| toggle_adv | output | 1 | Data toggle may advance |

## Verification
Every registered result has a fixed distance from the edge that samples its cause. Payload byte k is due after edge k+1 counted from start, and the CRC pair follows on the next two edges. done arrives one edge after tx_last on an OUT, and one edge after the rx_eop edge on an IN. The bench drives inputs on falling edges. It records outputs on falling edges, together with a free-running edge count, and compares the recorded edge counts with these distances. The combinational strobes tx_pop and rx_wr are checked a step after their inputs settle, within the same cycle.

// File: rtl/usbdbe_pkg.sv
package usbdbe_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'hA001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OUT_DATA, ST_OUT_CRC_LO, ST_OUT_CRC_HI, ST_OUT_END, ST_IN_DATA
  } dbe_state_t;

  typedef enum logic [1:0] {TX_NONE, TX_DATA, TX_CRC_LO, TX_CRC_HI} tx_sel_t;

  // One byte of the reflected CRC-16 update, least significant bit first.
  function automatic logic [CRC_W-1:0] crc16_step(input logic [CRC_W-1:0] crc,
                                                  input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] c;
    c = crc ^ {{(CRC_W-BYTE_W){1'b0}}, b};
    for (int i = 0; i < BYTE_W; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/usbdbe_crc.sv
module usbdbe_crc
  import usbdbe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= CRC_SEED;
    else if (en)    crc_q <= crc16_step(crc_q, din);
  end
endmodule

// File: rtl/usbdbe_txpath.sv
module usbdbe_txpath
  import usbdbe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  tx_sel_t           sel,
  input  logic              underrun,
  input  logic              corrupt,
  input  logic [BYTE_W-1:0] fifo_byte,
  input  logic [CRC_W-1:0]  crc,
  output logic [BYTE_W-1:0] slot_byte,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_last
);
  logic [BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0] crc_lo, crc_hi;

  // The correct CRC is the inverted remainder; the corrupted one is the raw remainder.
  assign crc_lo = corrupt ? crc[BYTE_W-1:0]     : ~crc[BYTE_W-1:0];
  assign crc_hi = corrupt ? crc[CRC_W-1:BYTE_W] : ~crc[CRC_W-1:BYTE_W];

  always_comb begin
    case (sel)
      TX_DATA:   slot_byte = underrun ? hold_q : fifo_byte;
      TX_CRC_LO: slot_byte = crc_lo;
      TX_CRC_HI: slot_byte = crc_hi;
      default:   slot_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
      tx_last  <= 1'b0;
      hold_q   <= '0;
    end else begin
      tx_valid <= (sel != TX_NONE);
      tx_byte  <= slot_byte;
      tx_last  <= (sel == TX_CRC_HI);
      if (clr)                 hold_q <= '0;
      else if (sel == TX_DATA) hold_q <= slot_byte;
    end
  end
endmodule

// File: rtl/usbdbe_ctrl.sv
module usbdbe_ctrl
  import usbdbe_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             dir_in,
  input  logic             iso,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             tx_empty,
  input  logic             rx_valid,
  input  logic             rx_full,
  input  logic             rx_eop,
  input  logic             rx_bad,
  output tx_sel_t          sel,
  output logic             tx_pop,
  output logic             underrun,
  output logic             clr,
  output logic             crc_en,
  output logic             corrupt,
  output logic             rx_wr,
  output logic             done,
  output logic             buf_err,
  output logic             xact_err,
  output logic             hs_ack,
  output logic             toggle_adv
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  dbe_state_t       state_q;
  logic [LEN_W-1:0] cnt_q;
  logic             err_q, iso_q;
  logic             ovr_now, in_err;

  always_comb begin
    case (state_q)
      ST_OUT_DATA:   sel = TX_DATA;
      ST_OUT_CRC_LO: sel = TX_CRC_LO;
      ST_OUT_CRC_HI: sel = TX_CRC_HI;
      default:       sel = TX_NONE;
    endcase
  end

  assign tx_pop   = (state_q == ST_OUT_DATA) && !tx_empty;
  assign underrun = (state_q == ST_OUT_DATA) && tx_empty;
  assign crc_en   = (state_q == ST_OUT_DATA);
  assign clr      = (state_q == ST_IDLE) && start;
  assign corrupt  = err_q;
  assign ovr_now  = (state_q == ST_IN_DATA) && rx_valid && rx_full;
  assign rx_wr    = (state_q == ST_IN_DATA) && rx_valid && !rx_full;
  assign in_err   = err_q || ovr_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      err_q      <= 1'b0;
      iso_q      <= 1'b0;
      done       <= 1'b0;
      buf_err    <= 1'b0;
      xact_err   <= 1'b0;
      hs_ack     <= 1'b0;
      toggle_adv <= 1'b0;
    end else begin
      done       <= 1'b0;
      buf_err    <= 1'b0;
      xact_err   <= 1'b0;
      hs_ack     <= 1'b0;
      toggle_adv <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          iso_q <= iso;
          err_q <= 1'b0;
          cnt_q <= pkt_len;
          if (dir_in)              state_q <= ST_IN_DATA;
          else if (pkt_len == '0)  state_q <= ST_OUT_CRC_LO;
          else                     state_q <= ST_OUT_DATA;
        end
        ST_OUT_DATA: begin
          if (tx_empty) err_q <= 1'b1;
          cnt_q <= cnt_q - LEN_ONE;
          if (cnt_q == LEN_ONE) state_q <= ST_OUT_CRC_LO;
        end
        ST_OUT_CRC_LO: state_q <= ST_OUT_CRC_HI;
        ST_OUT_CRC_HI: state_q <= ST_OUT_END;
        ST_OUT_END: begin
          done       <= 1'b1;
          buf_err    <= err_q;
          toggle_adv <= !err_q && !iso_q;
          state_q    <= ST_IDLE;
        end
        ST_IN_DATA: begin
          if (ovr_now) err_q <= 1'b1;
          if (rx_eop) begin
            done       <= 1'b1;
            buf_err    <= in_err;
            xact_err   <= rx_bad;
            hs_ack     <= !in_err && !rx_bad && !iso_q;
            toggle_adv <= !in_err && !rx_bad && !iso_q;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_dbe_responder.sv
module usb_dbe_responder
  import usbdbe_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             dir_in,
  input  logic             iso,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             tx_empty,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  output logic             tx_last,
  input  logic             rx_valid,
  input  logic             rx_full,
  input  logic             rx_eop,
  input  logic             rx_bad,
  output logic             rx_wr,
  output logic             done,
  output logic             buf_err,
  output logic             xact_err,
  output logic             hs_ack,
  output logic             toggle_adv
);
  tx_sel_t           sel;
  logic              underrun, clr, crc_en, corrupt;
  logic [BYTE_W-1:0] slot_byte;
  logic [CRC_W-1:0]  crc;

  usbdbe_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .dir_in(dir_in), .iso(iso),
    .pkt_len(pkt_len), .tx_empty(tx_empty), .rx_valid(rx_valid),
    .rx_full(rx_full), .rx_eop(rx_eop), .rx_bad(rx_bad), .sel(sel),
    .tx_pop(tx_pop), .underrun(underrun), .clr(clr), .crc_en(crc_en),
    .corrupt(corrupt), .rx_wr(rx_wr), .done(done), .buf_err(buf_err),
    .xact_err(xact_err), .hs_ack(hs_ack), .toggle_adv(toggle_adv)
  );

  usbdbe_crc crc_i (
    .clk(clk), .rst(rst), .clr(clr), .en(crc_en), .din(slot_byte), .crc_q(crc)
  );

  usbdbe_txpath tx_i (
    .clk(clk), .rst(rst), .clr(clr), .sel(sel), .underrun(underrun),
    .corrupt(corrupt), .fifo_byte(tx_data), .crc(crc), .slot_byte(slot_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last)
  );
endmodule

// File: rtl/usbdbe_chk.sv
module usbdbe_chk (
  input logic clk,
  input logic rst,
  input logic tx_empty,
  input logic tx_pop,
  input logic tx_valid,
  input logic tx_last,
  input logic rx_valid,
  input logic rx_full,
  input logic rx_wr,
  input logic done,
  input logic buf_err,
  input logic xact_err,
  input logic hs_ack,
  input logic toggle_adv
);
  assert_pop_guard_R2: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> !tx_empty);
  assert_last_valid_R3: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);
  assert_no_write_full_R6: assert property (@(posedge clk) disable iff (rst)
    rx_wr |-> (rx_valid && !rx_full));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_hs_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    hs_ack |-> (done && !buf_err && !xact_err));
  assert_toggle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    toggle_adv |-> (done && !buf_err && !xact_err));
endmodule

bind usb_dbe_responder usbdbe_chk chk_i (
  .clk(clk), .rst(rst), .tx_empty(tx_empty), .tx_pop(tx_pop),
  .tx_valid(tx_valid), .tx_last(tx_last), .rx_valid(rx_valid),
  .rx_full(rx_full), .rx_wr(rx_wr), .done(done), .buf_err(buf_err),
  .xact_err(xact_err), .hs_ack(hs_ack), .toggle_adv(toggle_adv)
);

// File: tb/usb_dbe_responder_tb_top.sv
module usb_dbe_responder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 11;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, dir_in = 0, iso = 0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic tx_empty = 1, rx_valid = 0, rx_full = 0, rx_eop = 0, rx_bad = 0;
  logic [7:0] tx_data = 8'h00;
  logic tx_pop, tx_valid, tx_last, rx_wr, done, buf_err, xact_err, hs_ack, toggle_adv;
  logic [7:0] tx_byte;

  usb_dbe_responder #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .dir_in(dir_in), .iso(iso),
    .pkt_len(pkt_len), .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_full(rx_full), .rx_eop(rx_eop), .rx_bad(rx_bad),
    .rx_wr(rx_wr), .done(done), .buf_err(buf_err), .xact_err(xact_err),
    .hs_ack(hs_ack), .toggle_adv(toggle_adv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Output monitor, sampled on falling edges.
  logic [7:0] cap_byte [0:31];
  bit         cap_last [0:31];
  int cap_n = 0, last_cyc = -1, d_cyc = -1;
  bit d_seen = 0, d_buf, d_xact, d_hs, d_tog;
  always @(negedge clk) begin
    if (tx_valid && cap_n < 32) begin
      cap_byte[cap_n] = tx_byte;
      cap_last[cap_n] = tx_last;
      cap_n++;
      if (tx_last) last_cyc = cyc;
    end
    if (done) begin
      d_seen = 1; d_cyc = cyc;
      d_buf = buf_err; d_xact = xact_err; d_hs = hs_ack; d_tog = toggle_adv;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  task automatic clear_mon();
    cap_n = 0; d_seen = 0; last_cyc = -1; d_cyc = -1;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!d_seen && n < 100) begin
      @(negedge clk); #1; n++;
    end
    chk(d_seen, "R7", "done pulse seen", d_seen, 1);
  endtask

  // OUT transaction: empty_mask marks underrun slots; src bytes supplied in order.
  task automatic run_out(input int len, input int mask, input bit is_iso,
                         input int seed, input bit use_ascii);
    logic [7:0] exp_b [0:31];
    logic [7:0] hold, b;
    logic [15:0] c;
    int p;
    bit err;
    clear_mon();
    @(negedge clk);
    start = 1; dir_in = 0; iso = is_iso; pkt_len = LEN_W'(len); tx_empty = 1;
    @(negedge clk);
    start = 0;
    p = 0; hold = 8'h00; c = 16'hFFFF; err = 0;
    for (int k = 0; k < len; k++) begin
      bit emp;
      emp = mask[k];
      b = use_ascii ? 8'(8'h31 + p) : 8'((p * 37 + seed * 11 + 5) & 255);
      tx_empty = emp;
      tx_data = emp ? 8'hEE : b;
      #1;
      chk(tx_pop == !emp, "R2", "tx_pop per slot", tx_pop, !emp);
      if (emp) begin
        err = 1; exp_b[k] = hold; // R4: repeat previous byte (0x00 at first)
      end else begin
        exp_b[k] = b; p++;
      end
      c = crc_upd(c, exp_b[k]);
      hold = exp_b[k];
      @(negedge clk);
    end
    tx_empty = 1; tx_data = 8'h00;
    // R3 normal CRC is inverted remainder; R5 corrupted is the raw remainder.
    exp_b[len]   = err ? c[7:0]  : ~c[7:0];
    exp_b[len+1] = err ? c[15:8] : ~c[15:8];
    wait_done();
    chk(cap_n == len + 2, "R2", "byte count", cap_n, len + 2);
    for (int k = 0; k < len + 2 && k < cap_n; k++) begin
      string rq;
      rq = (k >= len) ? (err ? "R5" : "R3") : (mask[k] ? "R4" : "R2");
      if (len == 0) rq = "R11";
      chk(cap_byte[k] == exp_b[k], rq, $sformatf("byte %0d", k), cap_byte[k], exp_b[k]);
      chk(cap_last[k] == (k == len + 1), "R3", "tx_last position", cap_last[k], k == len + 1);
    end
    chk(d_cyc == last_cyc + 1, "R7", "done one cycle after tx_last", d_cyc, last_cyc + 1);
    chk(d_buf == err, "R7", "buf_err out", d_buf, err);
    chk(d_xact == 0, "R9", "xact_err out", d_xact, 0);
    chk(d_hs == 0, "R8", "no handshake on out", d_hs, 0);
    chk(d_tog == (!err && !is_iso), "R10", "toggle out", d_tog, !err && !is_iso);
  endtask

  // IN transaction: full_mask marks bytes arriving while the receive FIFO is full.
  task automatic run_in(input int len, input int mask, input bit is_iso, input bit pkt_bad);
    bit err;
    int e_cyc;
    clear_mon();
    @(negedge clk);
    start = 1; dir_in = 1; iso = is_iso;
    @(negedge clk);
    start = 0;
    err = 0; e_cyc = -1;
    for (int k = 0; k < len; k++) begin
      rx_valid = 1; rx_full = mask[k]; rx_eop = (k == len - 1);
      rx_bad = pkt_bad && (k == len - 1);
      if (mask[k]) err = 1;
      #1;
      chk(rx_wr == !mask[k], "R6", "rx_wr", rx_wr, !mask[k]);
      if (k == len - 1) e_cyc = cyc + 1;
      @(negedge clk);
    end
    rx_valid = 0; rx_full = 0; rx_eop = 0; rx_bad = 0;
    wait_done();
    chk(d_cyc == e_cyc, "R7", "in done timing", d_cyc, e_cyc);
    chk(cap_n == 0, "R2", "no tx on in", cap_n, 0);
    chk(d_buf == err, "R6", "overrun flag", d_buf, err);
    chk(d_xact == pkt_bad, "R9", "xact_err follows rx_bad", d_xact, pkt_bad);
    chk(d_hs == (!err && !pkt_bad && !is_iso), "R8", "handshake", d_hs, !err && !pkt_bad && !is_iso);
    chk(d_tog == (!err && !pkt_bad && !is_iso), "R10", "toggle in", d_tog, !err && !pkt_bad && !is_iso);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog run did not complete actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    // R1 reset state
    chk({tx_valid, tx_last, tx_pop, rx_wr, done, buf_err, xact_err, hs_ack, toggle_adv} == 9'b0,
        "R1", "idle outputs", {tx_valid, tx_last, tx_pop, rx_wr, done}, 0);
    chk(tx_byte == 8'h00, "R1", "idle tx_byte", tx_byte, 0);
    // R3 known vector "123456789" -> C8 B4
    run_out(9, 0, 0, 0, 1);
    chk(cap_byte[9] == 8'hC8 && cap_byte[10] == 8'hB4, "R3", "known crc pair",
        {cap_byte[10], cap_byte[9]}, 16'hB4C8);
    // R11 zero length
    run_out(0, 0, 0, 0, 0);
    chk(cap_byte[0] == 8'h00 && cap_byte[1] == 8'h00, "R11", "zlp crc", {cap_byte[1], cap_byte[0]}, 0);
    // OUT sweep over every underrun pattern
    for (int len = 1; len <= 5; len++)
      for (int m = 0; m < (1 << len); m++)
        for (int s = 0; s < 2; s++)
          run_out(len, m, s[0], len * 32 + m, 0);
    // IN sweep over every overrun pattern, iso and packet error
    for (int len = 1; len <= 4; len++)
      for (int m = 0; m < (1 << len); m++)
        for (int s = 0; s < 4; s++)
          run_in(len, m, s[0], s[1]);
    finish_run();
  end
endmodule